// File: doc/BRIEF.md
# In-Order Retirement Buffer with Gated Producer Search

This block keeps a circular window of instructions in flight between issue and architectural update. The issue stage claims slots at the tail in program order, up to two per cycle. Execution units write results back out of order, each tagged with its slot number, on two independent ports. The block retires one slot per cycle from the head, and only once that slot has its result. An exception or a branch misprediction is only stored with the result. It takes effect when the slot becomes the oldest one. At that point the whole window is discarded and the pointers restart.

For operand forwarding, the issue stage presents an architectural register number. The block answers with the youngest in-flight slot that will write that register, that slot's completion status and its value. Beside the slots sits a per-register occupancy map that tells whether any in-flight slot targets a register. The associative compare over the slots runs only when that bit is set. Otherwise the search stays idle and reports no producer.

Top module: `rob_core`

## Requirements
- R1: After reset the window is empty (`rob_empty_o`=1, `rob_full_o`=0), nothing retires, no register is marked in use, and the next slot offered on lane 0 is 0.
- R2: Allocation lanes are taken in order: lane 0 receives the tail slot and lane 1 the following slot (modulo the depth). Lane 1 is accepted only when lane 0 is also requested in the same cycle. A lane-1 request on its own is ignored.
- R3: `rob_full_o` is 1 when fewer than two slots are free. While it is 1, allocation requests are ignored and the tail does not move.
- R4: Writebacks may arrive in any order on either port. The head slot retires (`retire_valid_o`=1 with its destination and value) only in a cycle where it already holds its result. Slots retire one per cycle, strictly in allocation order.
- R5: A writeback with its exception bit set is stored with the slot. When that slot is at the head, `trap_o`=1 and `flush_o`=1, `retire_valid_o`=0, and the next cycle the window is empty with every register marked free.
- R6: A writeback with its mispredict bit set retires normally at the head (`retire_valid_o`=1 with its value) while also raising `flush_o`. All younger slots are discarded and the window is empty the next cycle.
- R7: The lookup returns the youngest in-flight slot whose destination equals `lk_reg_i`, including across pointer wrap. It also returns that slot's done bit and, once done, its value.
- R8: `lk_search_o` equals the in-use bit of `lk_reg_i`. When it is 0, no search is made and `lk_hit_o`=0.
- R9: A register's in-use bit stays set while any in-flight slot targets it. It clears once the last such slot retires.
- R10: Allocation requests made in a cycle that flushes are dropped. After the flush the slot offered on lane 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | ALLOC_N | Allocation request per lane |
| alloc_dest_i | input | ALLOC_N*REG_W | Destination register per lane |
| alloc_idx_o | output | ALLOC_N*IDX_W | Slot number each lane would receive |
| rob_full_o | output | 1 | Fewer than ALLOC_N slots free |
| rob_empty_o | output | 1 | No slot in flight |
| wb_valid_i | input | WB_N | Writeback strobe per port |
| wb_idx_i | input | WB_N*IDX_W | Slot number per writeback |
| wb_data_i | input | WB_N*DATA_W | Result value per writeback |
| wb_exc_i | input | WB_N | Exception flag per writeback |
| wb_mispred_i | input | WB_N | Mispredict flag per writeback |
| retire_valid_o | output | 1 | Head slot updates architectural state |
| retire_dest_o | output | REG_W | Destination of retiring slot |
| retire_data_o | output | DATA_W | Value of retiring slot |
| flush_o | output | 1 | Window discarded at this edge |
| trap_o | output | 1 | Head slot carries an exception |
| lk_reg_i | input | REG_W | Register to look up |
| lk_search_o | output | 1 | Register is in use, search enabled |
| lk_hit_o | output | 1 | A producer was found |
| lk_idx_o | output | IDX_W | Youngest producer slot |
| lk_done_o | output | 1 | Producer already has its result |
| lk_data_o | output | DATA_W | Producer value |

## Verification
On every cycle the checker enforces several rules. An empty window has no register in use. A flush leaves the window empty with the search gated off. A trap never coincides with a retirement. Nothing retires from an empty window. A full window keeps its tail still. Other behaviour only shows up in the bench's scenarios, which compare each step with values it computes itself. These cover the youngest-match choice across pointer wrap, the exact retirement order after reverse-order writebacks, the occupancy bit surviving while a second writer is still in flight, and allocations dropped during a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    HEAD_IDLE,
    HEAD_RETIRE,
    HEAD_TRAP,
    HEAD_REDIRECT
  } head_act_e;

  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
    logic mis;
  } slot_flags_t;

  function automatic head_act_e head_decide(input slot_flags_t f);
    head_act_e act;
    act = HEAD_IDLE;
    if (f.valid && f.done) begin
      if (f.exc)      act = HEAD_TRAP;
      else if (f.mis) act = HEAD_REDIRECT;
      else            act = HEAD_RETIRE;
    end
    return act;
  endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_N = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int NA_W   = $clog2(ALLOC_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NA_W-1:0]  alloc_cnt_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);

  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      head_d = head_q + IDX_W'(retire_i);
      tail_d = tail_q + IDX_W'(alloc_cnt_i);
      cnt_d  = cnt_q + CNT_W'(alloc_cnt_i) - CNT_W'(retire_i);
    end
    upd_en = flush_i | retire_i | (alloc_cnt_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ALLOC_N = 2,
  parameter int WB_N    = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en_i   [ALLOC_N],
  input  logic [IDX_W-1:0]  alloc_idx_i  [ALLOC_N],
  input  logic [REG_W-1:0]  alloc_dest_i [ALLOC_N],
  input  logic              wb_en_i      [WB_N],
  input  logic [IDX_W-1:0]  wb_idx_i     [WB_N],
  input  logic [DATA_W-1:0] wb_data_i    [WB_N],
  input  logic              wb_exc_i     [WB_N],
  input  logic              wb_mis_i     [WB_N],
  input  logic              retire_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              flush_i,
  output slot_flags_t       flags_o      [DEPTH],
  output logic [REG_W-1:0]  dest_o       [DEPTH],
  output logic [DATA_W-1:0] data_o       [DEPTH]
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    slot_flags_t       flg_q, flg_d;
    logic [REG_W-1:0]  dst_q, dst_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              slot_en;

    always_comb begin
      flg_d   = flg_q;
      dst_d   = dst_q;
      val_d   = val_q;
      slot_en = 1'b0;
      for (int a = 0; a < ALLOC_N; a++) begin
        if (alloc_en_i[a] && (alloc_idx_i[a] == IDX_W'(e))) begin
          flg_d   = '{valid: 1'b1, done: 1'b0, exc: 1'b0, mis: 1'b0};
          dst_d   = alloc_dest_i[a];
          slot_en = 1'b1;
        end
      end
      for (int w = 0; w < WB_N; w++) begin
        if (wb_en_i[w] && flg_q.valid && (wb_idx_i[w] == IDX_W'(e))) begin
          flg_d.done = 1'b1;
          flg_d.exc  = wb_exc_i[w];
          flg_d.mis  = wb_mis_i[w];
          val_d      = wb_data_i[w];
          slot_en    = 1'b1;
        end
      end
      if (retire_i && (head_i == IDX_W'(e))) begin
        flg_d.valid = 1'b0;
        slot_en     = 1'b1;
      end
      if (flush_i) begin
        flg_d.valid = 1'b0;
        slot_en     = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q <= '0;
        dst_q <= '0;
        val_q <= '0;
      end else if (slot_en) begin
        flg_q <= flg_d;
        dst_q <= dst_d;
        val_q <= val_d;
      end
    end

    assign flags_o[e] = flg_q;
    assign dest_o[e]  = dst_q;
    assign data_o[e]  = val_q;
  end

endmodule

// File: rtl/rob_active_map.sv
module rob_active_map #(
  parameter int NREG    = 32,
  parameter int DEPTH   = 16,
  parameter int ALLOC_N = 2,
  localparam int REG_W  = $clog2(NREG),
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en_i  [ALLOC_N],
  input  logic [REG_W-1:0] inc_reg_i [ALLOC_N],
  input  logic             dec_en_i,
  input  logic [REG_W-1:0] dec_reg_i,
  input  logic             flush_i,
  output logic [NREG-1:0]  active_o
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
      for (int a = 0; a < ALLOC_N; a++) begin
        if (inc_en_i[a] && (inc_reg_i[a] == REG_W'(r))) begin
          cnt_d  = cnt_d + 1'b1;
          cnt_en = 1'b1;
        end
      end
      if (dec_en_i && (dec_reg_i == REG_W'(r))) begin
        cnt_d  = cnt_d - 1'b1;
        cnt_en = 1'b1;
      end
      if (flush_i) begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign active_o[r] = (cnt_q != '0);
  end

endmodule

// File: rtl/rob_dest_lookup.sv
module rob_dest_lookup
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              search_en_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [IDX_W-1:0]  head_i,
  input  slot_flags_t       flags_i [DEPTH],
  input  logic [REG_W-1:0]  dest_i  [DEPTH],
  input  logic [DATA_W-1:0] data_i  [DEPTH],
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);

  logic [IDX_W-1:0] slot;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    slot  = '0;
    if (search_en_i) begin
      for (int k = 0; k < DEPTH; k++) begin
        slot = head_i + IDX_W'(k);
        if (flags_i[slot].valid && (dest_i[slot] == reg_i)) begin
          hit_o = 1'b1;
          idx_o = slot;
        end
      end
    end
    done_o = hit_o & flags_i[idx_o].done;
    data_o = done_o ? data_i[idx_o] : '0;
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NREG    = 32,
  parameter int DATA_W  = 32,
  parameter int ALLOC_N = 2,
  parameter int WB_N    = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int REG_W  = $clog2(NREG),
  localparam int CNT_W  = IDX_W + 1,
  localparam int NA_W   = $clog2(ALLOC_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ALLOC_N-1:0]        alloc_valid_i,
  input  logic [ALLOC_N*REG_W-1:0]  alloc_dest_i,
  output logic [ALLOC_N*IDX_W-1:0]  alloc_idx_o,
  output logic                      rob_full_o,
  output logic                      rob_empty_o,
  input  logic [WB_N-1:0]           wb_valid_i,
  input  logic [WB_N*IDX_W-1:0]     wb_idx_i,
  input  logic [WB_N*DATA_W-1:0]    wb_data_i,
  input  logic [WB_N-1:0]           wb_exc_i,
  input  logic [WB_N-1:0]           wb_mispred_i,
  output logic                      retire_valid_o,
  output logic [REG_W-1:0]          retire_dest_o,
  output logic [DATA_W-1:0]         retire_data_o,
  output logic                      flush_o,
  output logic                      trap_o,
  input  logic [REG_W-1:0]          lk_reg_i,
  output logic                      lk_search_o,
  output logic                      lk_hit_o,
  output logic [IDX_W-1:0]          lk_idx_o,
  output logic                      lk_done_o,
  output logic [DATA_W-1:0]         lk_data_o
);

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [NA_W-1:0]   alloc_cnt;
  logic              lane_ok   [ALLOC_N];
  logic [IDX_W-1:0]  lane_idx  [ALLOC_N];
  logic [REG_W-1:0]  lane_dest [ALLOC_N];
  logic              wb_en     [WB_N];
  logic [IDX_W-1:0]  wb_idx    [WB_N];
  logic [DATA_W-1:0] wb_data   [WB_N];
  logic              wb_exc    [WB_N];
  logic              wb_mis    [WB_N];
  slot_flags_t       flags     [DEPTH];
  logic [REG_W-1:0]  dests     [DEPTH];
  logic [DATA_W-1:0] datas     [DEPTH];
  logic [NREG-1:0]   active;
  head_act_e         head_act;
  logic              retire;

  assign rob_full_o  = (count > CNT_W'(DEPTH - ALLOC_N));
  assign rob_empty_o = (count == '0);

  for (genvar a = 0; a < ALLOC_N; a++) begin : g_lane
    assign lane_idx[a]  = tail + IDX_W'(a);
    assign lane_dest[a] = alloc_dest_i[a*REG_W +: REG_W];
    assign alloc_idx_o[a*IDX_W +: IDX_W] = lane_idx[a];
    if (a == 0) begin : g_first
      assign lane_ok[a] = alloc_valid_i[a] & ~rob_full_o & ~flush_o;
    end else begin : g_next
      assign lane_ok[a] = alloc_valid_i[a] & lane_ok[a-1];
    end
  end

  always_comb begin
    alloc_cnt = '0;
    for (int a = 0; a < ALLOC_N; a++) alloc_cnt = alloc_cnt + NA_W'(lane_ok[a]);
  end

  for (genvar w = 0; w < WB_N; w++) begin : g_wb
    assign wb_en[w]   = wb_valid_i[w];
    assign wb_idx[w]  = wb_idx_i[w*IDX_W +: IDX_W];
    assign wb_data[w] = wb_data_i[w*DATA_W +: DATA_W];
    assign wb_exc[w]  = wb_exc_i[w];
    assign wb_mis[w]  = wb_mispred_i[w];
  end

  assign head_act       = head_decide(flags[head]);
  assign retire         = (head_act == HEAD_RETIRE) || (head_act == HEAD_REDIRECT);
  assign retire_valid_o = retire;
  assign retire_dest_o  = dests[head];
  assign retire_data_o  = datas[head];
  assign trap_o         = (head_act == HEAD_TRAP);
  assign flush_o        = (head_act == HEAD_TRAP) || (head_act == HEAD_REDIRECT);

  rob_ptr_ctl #(.DEPTH(DEPTH), .ALLOC_N(ALLOC_N)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_cnt_i (alloc_cnt),
    .retire_i    (retire),
    .flush_i     (flush_o),
    .head_o      (head),
    .tail_o      (tail),
    .count_o     (count)
  );

  rob_entry_store #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ALLOC_N(ALLOC_N), .WB_N(WB_N)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en_i   (lane_ok),
    .alloc_idx_i  (lane_idx),
    .alloc_dest_i (lane_dest),
    .wb_en_i      (wb_en),
    .wb_idx_i     (wb_idx),
    .wb_data_i    (wb_data),
    .wb_exc_i     (wb_exc),
    .wb_mis_i     (wb_mis),
    .retire_i     (retire),
    .head_i       (head),
    .flush_i      (flush_o),
    .flags_o      (flags),
    .dest_o       (dests),
    .data_o       (datas)
  );

  rob_active_map #(.NREG(NREG), .DEPTH(DEPTH), .ALLOC_N(ALLOC_N)) u_active (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en_i  (lane_ok),
    .inc_reg_i (lane_dest),
    .dec_en_i  (retire),
    .dec_reg_i (dests[head]),
    .flush_i   (flush_o),
    .active_o  (active)
  );

  assign lk_search_o = active[lk_reg_i];

  rob_dest_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
    .search_en_i (lk_search_o),
    .reg_i       (lk_reg_i),
    .head_i      (head),
    .flags_i     (flags),
    .dest_i      (dests),
    .data_i      (datas),
    .hit_o       (lk_hit_o),
    .idx_o       (lk_idx_o),
    .done_o      (lk_done_o),
    .data_o      (lk_data_o)
  );

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int ALLOC_N = 2,
  parameter int IDX_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ALLOC_N*IDX_W-1:0] alloc_idx_o,
  input logic                     rob_full_o,
  input logic                     rob_empty_o,
  input logic                     retire_valid_o,
  input logic                     flush_o,
  input logic                     trap_o,
  input logic                     lk_search_o
);

  // R8: an empty window has no register marked in use
  assert_empty_no_search_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty_o |-> !lk_search_o);

  // R5 / R6: a flush leaves the window empty and the search gated
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (rob_empty_o && !lk_search_o));

  // R5: the excepting slot never updates architectural state
  assert_trap_no_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !retire_valid_o);

  // R4: nothing retires from an empty window
  assert_retire_needs_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid_o |-> !rob_empty_o);

  // R3: a full window does not move its tail
  assert_full_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_full_o && !flush_o) |=> $stable(alloc_idx_o));

endmodule

bind rob_core rob_core_chk #(.ALLOC_N(ALLOC_N), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_idx_o    (alloc_idx_o),
  .rob_full_o     (rob_full_o),
  .rob_empty_o    (rob_empty_o),
  .retire_valid_o (retire_valid_o),
  .flush_o        (flush_o),
  .trap_o         (trap_o),
  .lk_search_o    (lk_search_o)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int NREG   = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int REG_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        alloc_valid_i;
  logic [2*REG_W-1:0] alloc_dest_i;
  logic [2*IDX_W-1:0] alloc_idx_o;
  logic              rob_full_o, rob_empty_o;
  logic [1:0]        wb_valid_i;
  logic [2*IDX_W-1:0] wb_idx_i;
  logic [2*DATA_W-1:0] wb_data_i;
  logic [1:0]        wb_exc_i, wb_mispred_i;
  logic              retire_valid_o;
  logic [REG_W-1:0]  retire_dest_o;
  logic [DATA_W-1:0] retire_data_o;
  logic              flush_o, trap_o;
  logic [REG_W-1:0]  lk_reg_i;
  logic              lk_search_o, lk_hit_o, lk_done_o;
  logic [IDX_W-1:0]  lk_idx_o;
  logic [DATA_W-1:0] lk_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    alloc_valid_i = '0;
    wb_valid_i    = '0;
    wb_exc_i      = '0;
    wb_mispred_i  = '0;
    #1;
  endtask

  task automatic alloc2(input logic [1:0] v, input int d0, input int d1);
    alloc_valid_i = v;
    alloc_dest_i  = {REG_W'(d1), REG_W'(d0)};
  endtask

  task automatic wb(input int port, input int idx, input int data, input bit exc, input bit mis);
    wb_valid_i[port] = 1'b1;
    wb_idx_i[port*IDX_W +: IDX_W]    = IDX_W'(idx);
    wb_data_i[port*DATA_W +: DATA_W] = DATA_W'(data);
    wb_exc_i[port]     = exc;
    wb_mispred_i[port] = mis;
  endtask

  task automatic look(input int r);
    lk_reg_i = REG_W'(r);
    #1;
  endtask

  initial begin
    int tail;
    int bad;
    rst_n = 1'b0;
    alloc_valid_i = '0; alloc_dest_i = '0;
    wb_valid_i = '0; wb_idx_i = '0; wb_data_i = '0; wb_exc_i = '0; wb_mispred_i = '0;
    lk_reg_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R1 reset state
    chk("R1 empty", rob_empty_o, 1);
    chk("R1 full", rob_full_o, 0);
    chk("R1 retire", retire_valid_o, 0);
    chk("R1 lane0 slot", alloc_idx_o[IDX_W-1:0], 0);
    bad = 0;
    for (int r = 0; r < NREG; r++) begin
      look(r);
      if (lk_search_o || lk_hit_o) bad++;
    end
    chk("R1 no register in use", bad, 0);

    // R2 lane slots
    alloc2(2'b11, 3, 5);
    #1;
    chk("R2 lane0 slot", alloc_idx_o[IDX_W-1:0], 0);
    chk("R2 lane1 slot", alloc_idx_o[2*IDX_W-1:IDX_W], 1);
    cyc();
    alloc2(2'b11, 3, 7);
    #1;
    chk("R2 lane0 slot second", alloc_idx_o[IDX_W-1:0], 2);
    cyc();
    look(3);
    chk("R7 youngest hit", lk_hit_o, 1);
    chk("R7 youngest idx", lk_idx_o, 2);
    chk("R7 not done", lk_done_o, 0);
    look(4);
    chk("R8 gated search", lk_search_o, 0);
    chk("R8 gated hit", lk_hit_o, 0);

    // R4 out-of-order writeback, head not done
    wb(0, 2, 'h22, 0, 0);
    wb(1, 1, 'h11, 0, 0);
    #1;
    chk("R4 head not done no retire", retire_valid_o, 0);
    cyc();
    chk("R4 still no retire", retire_valid_o, 0);
    look(3);
    chk("R7 done", lk_done_o, 1);
    chk("R7 data", lk_data_o, 'h22);
    wb(0, 0, 'hA0, 0, 0);
    wb(1, 3, 'h33, 0, 0);
    cyc();
    chk("R4 retire 0 valid", retire_valid_o, 1);
    chk("R4 retire 0 dest", retire_dest_o, 3);
    chk("R4 retire 0 data", retire_data_o, 'hA0);
    cyc();
    chk("R4 retire 1 data", retire_data_o, 'h11);
    chk("R4 retire 1 dest", retire_dest_o, 5);
    look(3);
    chk("R9 still in use", lk_search_o, 1);
    chk("R9 remaining producer", lk_idx_o, 2);
    cyc();
    chk("R4 retire 2 data", retire_data_o, 'h22);
    cyc();
    chk("R4 retire 3 data", retire_data_o, 'h33);
    look(3);
    chk("R9 cleared after last writer", lk_search_o, 0);
    cyc();
    chk("R4 drained", rob_empty_o, 1);
    chk("R4 nothing to retire", retire_valid_o, 0);

    // R2 lane1 alone ignored
    alloc2(2'b10, 0, 21);
    cyc();
    look(21);
    chk("R2 lone lane1 not in use", lk_search_o, 0);
    chk("R2 lone lane1 empty", rob_empty_o, 1);
    chk("R2 lone lane1 tail", alloc_idx_o[IDX_W-1:0], 4);

    // R3 fill: slots 4..17 (wraps) in pairs, then one more
    for (int k = 0; k < 7; k++) begin
      alloc2(2'b11, 10, 11);
      cyc();
    end
    chk("R3 fourteen not full", rob_full_o, 0);
    alloc2(2'b01, 12, 0);
    cyc();
    chk("R3 fifteen full", rob_full_o, 1);
    chk("R3 tail before", alloc_idx_o[IDX_W-1:0], 3);
    alloc2(2'b11, 20, 20);
    cyc();
    look(20);
    chk("R3 blocked alloc", lk_search_o, 0);
    chk("R3 tail after", alloc_idx_o[IDX_W-1:0], 3);
    look(10);
    chk("R7 youngest across wrap", lk_idx_o, 0);
    look(11);
    chk("R7 youngest across wrap lane1", lk_idx_o, 1);

    // R5 exception at head (slot 4); R10 alloc during flush
    wb(0, 4, 'hEE, 1, 0);
    cyc();
    alloc2(2'b01, 22, 0);
    #1;
    chk("R5 trap", trap_o, 1);
    chk("R5 flush", flush_o, 1);
    chk("R5 no retire", retire_valid_o, 0);
    cyc();
    chk("R5 empty after trap", rob_empty_o, 1);
    look(10);
    chk("R5 registers free", lk_search_o, 0);
    look(22);
    chk("R10 alloc dropped", lk_search_o, 0);
    chk("R10 lane0 slot restarts", alloc_idx_o[IDX_W-1:0], 0);

    // R6 mispredict at head
    alloc2(2'b11, 8, 9);
    cyc();
    alloc2(2'b01, 8, 0);
    cyc();
    wb(0, 0, 'h55, 0, 1);
    wb(1, 1, 'h66, 0, 0);
    cyc();
    chk("R6 retire valid", retire_valid_o, 1);
    chk("R6 retire data", retire_data_o, 'h55);
    chk("R6 retire dest", retire_dest_o, 8);
    chk("R6 flush", flush_o, 1);
    chk("R6 no trap", trap_o, 0);
    cyc();
    chk("R6 empty", rob_empty_o, 1);
    look(9);
    chk("R6 younger discarded", lk_search_o, 0);

    // R4/R7 sweep: n writers of one register, reverse-order writeback
    tail = 0;
    for (int n = 1; n <= 6; n++) begin
      for (int i = 0; i < n; i++) begin
        alloc2(2'b01, 4, 0);
        cyc();
      end
      look(4);
      chk("R7 sweep youngest", lk_idx_o, (tail + n - 1) % DEPTH);
      for (int i = n - 1; i >= 0; i--) begin
        wb(i % 2, (tail + i) % DEPTH, 100 + i, 0, 0);
        cyc();
      end
      look(4);
      chk("R7 sweep data", lk_data_o, 100 + n - 1);
      for (int i = 0; i < n; i++) begin
        chk("R4 sweep order valid", retire_valid_o, 1);
        chk("R4 sweep order data", retire_data_o, 100 + i);
        cyc();
      end
      chk("R9 sweep released", lk_search_o, 0);
      chk("R4 sweep empty", rob_empty_o, 1);
      tail = tail + n;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule